// File: doc/BRIEF.md
# Clock Rate Change Sequencer

This block runs the handshake that moves a system between three clock rates: full speed, half speed and one thirty-second speed. Software writes a control value through a small write-only register port. When a write produces a fresh 0-to-1 transition on exactly one rate bit, the sequencer starts. It drops an active-low freeze request and waits for the freeze acknowledge. It then drives three active-low rate-change lines low and later raises a PLL bypass. After that it undoes both, in reverse order, and releases freeze. Each gap in this sequence comes from its own programmable count.

All counts are in cycles of the block's own clock, which runs at half the system rate. The rate chosen at trigger time is latched and presented on a 2-bit output for the external divider. A busy output covers the whole sequence, and a new request that arrives during a sequence is dropped. Software is expected to clear the control value about sixteen system clocks after setting it, so that the next request can be an edge again.

Top module: `clkchg_seq`

## Requirements
- R1: After reset, freeze_n is 1, clk_chg_n is 3'b111, pll_bypass is 0, busy is 0 and rate_sel is 2'b00.
- R2: Register address 0 is the control value, and only three of its bits count: bit 0 selects full speed (rate_sel 2'b00), bit 1 selects half speed (2'b01) and bit 5 selects 1/32 speed (2'b10). Bits 2, 3, 4, 6 and 7 are ignored. The control value is the only way to start a sequence.
- R3: A write to address 0 starts a sequence only if, after the write, exactly one of the three rate bits is set and that bit was 0 before the write. Writing the same value again, or a value with two or more rate bits set, starts nothing.
- R4: On the clock edge that accepts a starting write, freeze_n goes low and busy goes high, and rate_sel takes the code of the requested rate and holds it until the next accepted start.
- R5: While freeze_ack is low, the sequencer holds freeze_n low and clk_chg_n high for as long as it takes.
- R6: Let the edge that samples freeze_ack high be edge E. With the 8-bit count at address 1 equal to A, all three clk_chg_n lines go low together at edge E+A+1.
- R7: With the 16-bit count at address 2 equal to B, pll_bypass rises B+1 cycles after clk_chg_n went low.
- R8: With the 8-bit count at address 3 equal to C, pll_bypass falls C+1 cycles after it rose.
- R9: With the 8-bit count at address 4 equal to D, clk_chg_n returns to 3'b111 D+1 cycles after pll_bypass fell.
- R10: With the 32-bit count at address 5 equal to S, freeze_n returns high and busy falls S+1 cycles after clk_chg_n was released.
- R11: A write to the control value while busy is high starts nothing and does not change rate_sel, but it still updates the stored value that later edge checks compare against.
- R12: clk_chg_n is low only while freeze_n is low, and pll_bypass is high only while clk_chg_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (half the system rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 control, 1 to 5 phase counts |
| cfg_wdata | input | 32 | Write data, low bits used per register width |
| freeze_ack | input | 1 | Acknowledge that the system is frozen |
| freeze_n | output | 1 | Active-low freeze request |
| clk_chg_n | output | 3 | Active-low rate-change lines, moved together |
| pll_bypass | output | 1 | PLL bypass request |
| busy | output | 1 | High from the accepted start until freeze is released |
| rate_sel | output | 2 | Latched rate code for the divider |

## Verification
A wrong phase or a miscounted delay shows at the ports on the first cycle where freeze_n, clk_chg_n or pll_bypass toggles one edge early or late, so it is found within one cycle of the gap in question. A wrong edge detector or one-hot qualifier shows as busy rising, or failing to rise, on the cycle right after the control write. A stale latched rate shows on rate_sel from that same cycle on. The per-cycle comparison against a behavioural model of the phase sequence therefore catches each of these within a cycle of the fault.

// File: rtl/clkchg_pkg.sv
package clkchg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FREEZE = 3'd1,
        ST_ACT    = 3'd2,
        ST_ABT    = 3'd3,
        ST_DABT   = 3'd4,
        ST_DACT   = 3'd5,
        ST_PST    = 3'd6
    } seq_state_e;

    localparam int unsigned RATE_W = 2;

    typedef enum logic [RATE_W-1:0] {
        RATE_FULL = 2'd0,
        RATE_HALF = 2'd1,
        RATE_SLOW = 2'd2
    } rate_e;

    // control bit positions decoded by the register block
    localparam int unsigned BIT_FULL = 0;
    localparam int unsigned BIT_HALF = 1;
    localparam int unsigned BIT_SLOW = 5;
    localparam int unsigned NUM_RATES = 3;

    // register indices
    localparam int unsigned ADR_CTRL = 0;
    localparam int unsigned ADR_ACT  = 1;
    localparam int unsigned ADR_ABT  = 2;
    localparam int unsigned ADR_DABT = 3;
    localparam int unsigned ADR_DACT = 4;
    localparam int unsigned ADR_PST  = 5;

endpackage

// File: rtl/clkchg_regs.sv
module clkchg_regs
    import clkchg_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ACT_W  = 8,
    parameter int unsigned ABT_W  = 16,
    parameter int unsigned DABT_W = 8,
    parameter int unsigned DACT_W = 8,
    parameter int unsigned PST_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busy_i,
    output logic [ACT_W-1:0]  act_o,
    output logic [ABT_W-1:0]  abt_o,
    output logic [DABT_W-1:0] dabt_o,
    output logic [DACT_W-1:0] dact_o,
    output logic [PST_W-1:0]  pst_o,
    output logic              trig_o,
    output rate_e             trig_rate_o
);

    typedef struct packed {
        logic [NUM_RATES-1:0] ctrl;
        logic [ACT_W-1:0]     act;
        logic [ABT_W-1:0]     abt;
        logic [DABT_W-1:0]    dabt;
        logic [DACT_W-1:0]    dact;
        logic [PST_W-1:0]     pst;
    } regs_t;

    regs_t reg_d, reg_q;
    logic [NUM_RATES-1:0] rate_bits;
    logic [NUM_RATES-1:0] rise;
    logic                 ctrl_wr;

    // only the three rate bits are kept; reserved positions fall away here
    assign rate_bits = {wdata_i[BIT_SLOW], wdata_i[BIT_HALF], wdata_i[BIT_FULL]};
    assign ctrl_wr   = we_i && (addr_i == ADDR_W'(ADR_CTRL));
    assign rise      = rate_bits & ~reg_q.ctrl;

    always_comb begin
        reg_d       = reg_q;
        trig_o      = 1'b0;
        trig_rate_o = RATE_FULL;
        if (we_i) begin
            case (addr_i)
                ADDR_W'(ADR_CTRL): reg_d.ctrl = rate_bits;
                ADDR_W'(ADR_ACT):  reg_d.act  = wdata_i[ACT_W-1:0];
                ADDR_W'(ADR_ABT):  reg_d.abt  = wdata_i[ABT_W-1:0];
                ADDR_W'(ADR_DABT): reg_d.dabt = wdata_i[DABT_W-1:0];
                ADDR_W'(ADR_DACT): reg_d.dact = wdata_i[DACT_W-1:0];
                ADDR_W'(ADR_PST):  reg_d.pst  = wdata_i[PST_W-1:0];
                default: ;
            endcase
        end
        if (ctrl_wr && !busy_i && $onehot(rate_bits) && (rise != '0)) begin
            trig_o = 1'b1;
        end
        if (rate_bits[2])      trig_rate_o = RATE_SLOW;
        else if (rate_bits[1]) trig_rate_o = RATE_HALF;
        else                   trig_rate_o = RATE_FULL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign act_o  = reg_q.act;
    assign abt_o  = reg_q.abt;
    assign dabt_o = reg_q.dabt;
    assign dact_o = reg_q.dact;
    assign pst_o  = reg_q.pst;

    // R11: no start request is passed on while a sequence runs
    a_r11_no_trig_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !trig_o);

    // R3: a start needs exactly one rate bit set in the written value
    a_r3_onehot_start: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ($countones({wdata_i[BIT_SLOW], wdata_i[BIT_HALF], wdata_i[BIT_FULL]}) == 1));

    // R3: a start needs a written rate bit that was clear before
    a_r3_edge_start: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> (reg_q.ctrl != $past(reg_q.ctrl)));

endmodule

// File: rtl/clkchg_fsm.sv
module clkchg_fsm
    import clkchg_pkg::*;
#(
    parameter int unsigned ACT_W  = 8,
    parameter int unsigned ABT_W  = 16,
    parameter int unsigned DABT_W = 8,
    parameter int unsigned DACT_W = 8,
    parameter int unsigned PST_W  = 32,
    parameter int unsigned CHG_N  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  rate_e             trig_rate_i,
    input  logic              ack_i,
    input  logic [ACT_W-1:0]  act_i,
    input  logic [ABT_W-1:0]  abt_i,
    input  logic [DABT_W-1:0] dabt_i,
    input  logic [DACT_W-1:0] dact_i,
    input  logic [PST_W-1:0]  pst_i,
    output logic              freeze_n_o,
    output logic [CHG_N-1:0]  chg_n_o,
    output logic              bypass_o,
    output logic              busy_o,
    output rate_e             rate_o
);

    localparam int unsigned W1    = (ACT_W > ABT_W) ? ACT_W : ABT_W;
    localparam int unsigned W2    = (DABT_W > DACT_W) ? DABT_W : DACT_W;
    localparam int unsigned W3    = (W1 > W2) ? W1 : W2;
    localparam int unsigned CNT_W = (W3 > PST_W) ? W3 : PST_W;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        rate_e            rate;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic cnt_done;
    logic chg_active;

    assign cnt_done = (fsm_q.cnt == '0);

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.state)
            ST_IDLE: begin
                if (trig_i) begin
                    fsm_d.state = ST_FREEZE;
                    fsm_d.rate  = trig_rate_i;
                end
            end
            ST_FREEZE: begin
                if (ack_i) begin
                    fsm_d.state = ST_ACT;
                    fsm_d.cnt   = CNT_W'(act_i);
                end
            end
            ST_ACT: begin
                if (cnt_done) begin
                    fsm_d.state = ST_ABT;
                    fsm_d.cnt   = CNT_W'(abt_i);
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            ST_ABT: begin
                if (cnt_done) begin
                    fsm_d.state = ST_DABT;
                    fsm_d.cnt   = CNT_W'(dabt_i);
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            ST_DABT: begin
                if (cnt_done) begin
                    fsm_d.state = ST_DACT;
                    fsm_d.cnt   = CNT_W'(dact_i);
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            ST_DACT: begin
                if (cnt_done) begin
                    fsm_d.state = ST_PST;
                    fsm_d.cnt   = CNT_W'(pst_i);
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            ST_PST: begin
                if (cnt_done) begin
                    fsm_d.state = ST_IDLE;
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, cnt: '0, rate: RATE_FULL};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign chg_active = (fsm_q.state == ST_ABT) || (fsm_q.state == ST_DABT) ||
                        (fsm_q.state == ST_DACT);
    assign freeze_n_o = (fsm_q.state == ST_IDLE);
    assign busy_o     = (fsm_q.state != ST_IDLE);
    assign bypass_o   = (fsm_q.state == ST_DABT);
    assign rate_o     = fsm_q.rate;

    for (genvar g = 0; g < CHG_N; g++) begin : g_chg
        assign chg_n_o[g] = !chg_active;
    end

    // R4: an accepted start freezes on the next edge
    a_r4_start_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !busy_o) |=> (!freeze_n_o && busy_o));

    // R5: without acknowledge the freeze phase holds
    a_r5_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_FREEZE && !ack_i) |=> (fsm_q.state == ST_FREEZE && chg_n_o == '1));

    // R11: latched rate does not move during a sequence
    a_r11_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && fsm_q.state != ST_IDLE) |=> $stable(rate_o));

    // R12: bypass only rises while the change lines are already low
    a_r12_bypass_in_chg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_o) |-> ($past(chg_n_o) == '0));

    // R10: freeze releases only after change lines and bypass are released
    a_r10_freeze_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze_n_o) |-> ($past(chg_n_o) == '1 && !$past(bypass_o)));

    // R12: change lines drop only once freeze is already low
    a_r12_chg_in_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chg_n_o[0]) |-> !$past(freeze_n_o));

endmodule

// File: rtl/clkchg_seq.sv
module clkchg_seq
    import clkchg_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ACT_W  = 8,
    parameter int unsigned ABT_W  = 16,
    parameter int unsigned DABT_W = 8,
    parameter int unsigned DACT_W = 8,
    parameter int unsigned PST_W  = 32,
    parameter int unsigned CHG_N  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              freeze_ack,
    output logic              freeze_n,
    output logic [CHG_N-1:0]  clk_chg_n,
    output logic              pll_bypass,
    output logic              busy,
    output logic [RATE_W-1:0] rate_sel
);

    logic [ACT_W-1:0]  act;
    logic [ABT_W-1:0]  abt;
    logic [DABT_W-1:0] dabt;
    logic [DACT_W-1:0] dact;
    logic [PST_W-1:0]  pst;
    logic              trig;
    rate_e             trig_rate;
    rate_e             rate;

    clkchg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACT_W(ACT_W), .ABT_W(ABT_W),
        .DABT_W(DABT_W), .DACT_W(DACT_W), .PST_W(PST_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
        .wdata_i(cfg_wdata), .busy_i(busy), .act_o(act), .abt_o(abt),
        .dabt_o(dabt), .dact_o(dact), .pst_o(pst), .trig_o(trig),
        .trig_rate_o(trig_rate)
    );

    clkchg_fsm #(
        .ACT_W(ACT_W), .ABT_W(ABT_W), .DABT_W(DABT_W), .DACT_W(DACT_W),
        .PST_W(PST_W), .CHG_N(CHG_N)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .trig_rate_i(trig_rate),
        .ack_i(freeze_ack), .act_i(act), .abt_i(abt), .dabt_i(dabt),
        .dact_i(dact), .pst_i(pst), .freeze_n_o(freeze_n),
        .chg_n_o(clk_chg_n), .bypass_o(pll_bypass), .busy_o(busy),
        .rate_o(rate)
    );

    assign rate_sel = rate;

endmodule

// File: tb/test_clkchg_seq.sv
module test_clkchg_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        freeze_ack = 1'b0;
    logic        freeze_n;
    logic [2:0]  clk_chg_n;
    logic        pll_bypass;
    logic        busy;
    logic [1:0]  rate_sel;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    int      m_ph = 0;
    longint  m_left = 0;
    int      m_rate = 0;
    int      m_ctrl = 0;
    longint  m_dly [1:5];

    always #2 clk = ~clk;

    clkchg_seq i_clkchg_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .freeze_ack(freeze_ack), .freeze_n(freeze_n),
        .clk_chg_n(clk_chg_n), .pll_bypass(pll_bypass), .busy(busy),
        .rate_sel(rate_sel)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_rate = 0; m_ctrl = 0;
            for (int i = 1; i <= 5; i++) m_dly[i] = 0;
        end else begin
            int     nph;
            longint nleft;
            nph = m_ph; nleft = m_left;
            if (m_ph == 1) begin
                if (freeze_ack) begin nph = 2; nleft = m_dly[1]; end
            end else if (m_ph >= 2) begin
                if (m_left == 0) begin
                    if (m_ph == 6) nph = 0;
                    else begin nph = m_ph + 1; nleft = m_dly[m_ph]; end
                end else nleft = m_left - 1;
            end
            if (cfg_we) begin
                if (cfg_addr == 0) begin
                    int v;
                    v = (cfg_wdata[5] ? 4 : 0) + (cfg_wdata[1] ? 2 : 0) + (cfg_wdata[0] ? 1 : 0);
                    if (m_ph == 0 && (v == 1 || v == 2 || v == 4) && ((v & ~m_ctrl) != 0)) begin
                        nph = 1;
                        m_rate = (v == 1) ? 0 : (v == 2) ? 1 : 2;
                    end
                    m_ctrl = v;
                end else if (cfg_addr == 2) m_dly[2] = cfg_wdata & 32'hFFFF;
                else if (cfg_addr == 5) m_dly[5] = cfg_wdata;
                else if (cfg_addr <= 4) m_dly[cfg_addr] = cfg_wdata & 32'hFF;
            end
            m_ph = nph; m_left = nleft;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(cur_req, "freeze_n", freeze_n, (m_ph == 0) ? 1 : 0);
            chk(cur_req, "clk_chg_n", clk_chg_n, (m_ph >= 3 && m_ph <= 5) ? 0 : 7);
            chk(cur_req, "pll_bypass", pll_bypass, (m_ph == 4) ? 1 : 0);
            chk(cur_req, "busy", busy, (m_ph != 0) ? 1 : 0);
            chk(cur_req, "rate_sel", rate_sel, m_rate);
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R1";
        chk("R1", "reset freeze_n", freeze_n, 1);
        chk("R1", "reset clk_chg_n", clk_chg_n, 7);
        chk("R1", "reset bypass", pll_bypass, 0);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset rate_sel", rate_sel, 0);

        wr(1, 2); wr(2, 3); wr(3, 1); wr(4, 0); wr(5, 4);

        cur_req = "R2";              // reserved bit 2 only: nothing starts
        wr(0, 32'h04); idle(4);
        chk("R2", "reserved-only busy", busy, 0);

        cur_req = "R5";              // half speed, acknowledge held back
        wr(0, 32'h02);
        chk("R4", "start busy", busy, 1);
        chk("R4", "start rate", rate_sel, 1);
        idle(6);
        chk("R5", "waiting freeze_n", freeze_n, 0);
        freeze_ack = 1'b1;
        cur_req = "R6";
        idle(2);
        cur_req = "R11";             // writes during the sequence are dropped
        wr(0, 32'h00); wr(0, 32'h20);
        cur_req = "R9";
        wait_done(); freeze_ack = 1'b0;
        chk("R11", "rate after busy write", rate_sel, 1);
        idle(3);

        cur_req = "R3";              // 0x20 already stored: no edge
        wr(0, 32'h20); idle(3);
        chk("R3", "repeat value busy", busy, 0);
        wr(0, 32'h00);
        wr(0, 32'h03); idle(3);
        chk("R3", "two bits busy", busy, 0);
        wr(0, 32'h00);
        wr(0, 32'h21); idle(3);
        chk("R3", "bits 0 and 5 busy", busy, 0);
        wr(0, 32'h00);

        cur_req = "R8";              // all counts zero, ack already high
        wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0); wr(5, 0);
        freeze_ack = 1'b1;
        wr(0, 32'h01);
        chk("R4", "full rate", rate_sel, 0);
        wait_done(); idle(3);
        wr(0, 32'h00);

        cur_req = "R7";              // long bypass wait beyond 8 bits, 1/32
        wr(1, 5); wr(2, 300); wr(3, 7); wr(4, 9); wr(5, 20);
        wr(0, 32'h20);
        chk("R4", "slow rate", rate_sel, 2);
        cur_req = "R10";
        wait_done(); idle(3);

        cur_req = "R2";              // reserved bit 2 with bit 1: half speed
        wr(0, 32'h00);
        wr(3, 32'hFFFF_FF02);        // only low byte used
        wr(0, 32'h06);
        chk("R2", "reserved masked rate", rate_sel, 1);
        cur_req = "R12";
        wait_done(); idle(3);
        chk("R10", "final busy", busy, 0);
        chk("R10", "final freeze_n", freeze_n, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule